// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register Block

This block keeps the configuration header of a single PCI function. A host controller reaches it one byte at a time. Each request word carries a byte address, a write byte, read and write flags and a function number. The block answers on the next cycle with a response word. The response echoes the address, the flags and the function number, and carries the addressed register byte. A request with neither flag set is not a configuration access. It is forwarded unchanged on a separate pass-through output, to be used by whatever sits behind this block.

The bus engine signals protocol events to the block as single-cycle pulses: parity error, system error, master abort, target abort received and target abort signalled. Each pulse sets a sticky bit in the status half-word. Software clears a sticky bit by writing a 1 to it. The block also holds the command register, a few writable housekeeping bytes of the header, and the identity fields, which are fixed by module parameters.

Top module: `pci_cfg_space`

## Requirements
- R1: After reset, bytes 0x04, 0x05, 0x06 and 0x07 read 0x80, 0x00, 0xA0 and 0x02. Together these form the dword 0x02A00080.
- R2: Command bits 9:0 are writable: bits 7:0 at byte 0x04, and bits 9:8 in bits 1:0 of byte 0x05. Bits 15:10 of the command register always read 0.
- R3: Status bits 31, 30, 29, 28, 27 and 24 sit in byte 0x07, in bits 7, 6, 5, 4, 3 and 0. Each is cleared only by writing 1 to that bit of byte 0x07. Writing 0 leaves the bit unchanged.
- R4: The remaining status bits are fixed. DEVSEL timing is 01 (byte 0x07 bits 2:1). Fast back-to-back capable (bit 23) and 66 MHz capable (bit 21) read 1. The capabilities bit (20), bit 22 and bits 19:16 read 0. Writes do not change any of them.
- R5: A pulse on ev_parity_err, ev_serr, ev_master_abort, ev_target_abort_rcvd, ev_target_abort_sig or ev_master_data_perr sets status bit 31, 30, 29, 28, 27 or 24 respectively.
- R6: A master abort pulse that arrives while ev_special_cycle is high does not set bit 29.
- R7: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by that same write still clear.
- R8: Vendor ID (0x00), device ID (0x02), revision (0x08), class code (0x09..0x0B), subsystem vendor ID (0x2C), subsystem ID (0x2E), interrupt pin (0x3D), min grant (0x3E) and max latency (0x3F) return their parameter values, least significant byte first. Writes do not change them.
- R9: Cache line size (0x0C), latency timer (0x0D) and interrupt line (0x3C) are readable and writable, and reset to 0x00. The header type byte (0x0E) and the BIST byte (0x0F) read 0x00.
- R10: Unimplemented bytes read 0x00 and ignore writes. These include the base address registers (0x10..0x27), the expansion ROM pointer (0x30) and the capabilities pointer (0x34).
- R11: A request with bit 16 (write) or bit 17 (read) set gets a response one cycle later. The response keeps bits [7:0], [16], [17] and [20:18] from the request. Bits [15:8] hold the register byte as it was before that request's write.
- R12: A request whose function number [20:18] is nonzero gets a response with byte 0x00 and writes nothing.
- R13: A request with bits [17:16] both 0 produces no response. One cycle later it appears unchanged on pass_data, with pass_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word valid |
| req_data | input | 21 | {function, read, write, write byte, byte address} |
| ev_parity_err | input | 1 | Pulse: parity error detected |
| ev_serr | input | 1 | Pulse: system error signalled |
| ev_master_abort | input | 1 | Pulse: transaction ended by master abort |
| ev_special_cycle | input | 1 | Qualifies ev_master_abort as ending a special cycle |
| ev_target_abort_rcvd | input | 1 | Pulse: target abort received as master |
| ev_target_abort_sig | input | 1 | Pulse: target abort signalled as target |
| ev_master_data_perr | input | 1 | Pulse: data parity error seen as master |
| rsp_valid | output | 1 | Configuration response valid |
| rsp_data | output | 21 | {function, read, write, read byte, byte address} |
| pass_valid | output | 1 | Forwarded non-configuration request valid |
| pass_data | output | 21 | Forwarded request word |

## Verification
An event pulse that sets a sticky status bit can land in the same cycle as a host write that clears the same bit. The bench provokes this by raising the target-abort-received pulse on the same clock edge as a write of 1 to that bit of byte 0x07. The same write also clears a second, unrelated sticky bit. A read-back of byte 0x07 must show the contested bit set and the unrelated bit cleared.

// File: rtl/pci_cfg_space.sv
module pci_cfg_space #(
  parameter logic [15:0] VENDOR_ID     = 16'h1234,
  parameter logic [15:0] DEVICE_ID     = 16'h5A3C,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h0B4000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h1234,
  parameter logic [15:0] SUBSYS_ID     = 16'h00C1,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h04,
  parameter logic [7:0]  MAX_LAT       = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [20:0] req_data,
  input  logic        ev_parity_err,
  input  logic        ev_serr,
  input  logic        ev_master_abort,
  input  logic        ev_special_cycle,
  input  logic        ev_target_abort_rcvd,
  input  logic        ev_target_abort_sig,
  input  logic        ev_master_data_perr,
  output logic        rsp_valid,
  output logic [20:0] rsp_data,
  output logic        pass_valid,
  output logic [20:0] pass_data
);

  logic [9:0]  cmd;
  logic [5:0]  sticky;   // {31,30,29,28,27,24}
  logic [7:0]  cache_line, lat_timer, int_line;
  logic [31:0] dword;
  logic [7:0]  rd_byte;

  wire [7:0] addr   = req_data[7:0];
  wire [7:0] wbyte  = req_data[15:8];
  wire       wr     = req_data[16];
  wire       rd     = req_data[17];
  wire       fn0    = (req_data[20:18] == 3'd0);
  wire       cfg    = req_valid && (wr || rd);
  wire       do_wr  = cfg && wr && fn0;

  wire [15:0] status = {sticky[5:1], 2'b01, sticky[0], 8'hA0};

  always_comb begin
    case (addr[7:2])
      6'd0:    dword = {DEVICE_ID, VENDOR_ID};
      6'd1:    dword = {status, 6'b0, cmd};
      6'd2:    dword = {CLASS_CODE, REVISION};
      6'd3:    dword = {16'h0000, lat_timer, cache_line};
      6'd11:   dword = {SUBSYS_ID, SUBSYS_VENDOR};
      6'd15:   dword = {MAX_LAT, MIN_GNT, INT_PIN, int_line};
      default: dword = 32'h0;
    endcase
  end

  wire [31:0] shifted = dword >> {addr[1:0], 3'b000};
  assign rd_byte = fn0 ? shifted[7:0] : 8'h00;

  wire [5:0] ev_set = {ev_parity_err, ev_serr, ev_master_abort && !ev_special_cycle,
                       ev_target_abort_rcvd, ev_target_abort_sig, ev_master_data_perr};
  wire [5:0] ev_clr = (do_wr && addr == 8'h07) ? {wbyte[7:3], wbyte[0]} : 6'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd        <= 10'h080;
      sticky     <= 6'b0;
      cache_line <= 8'h00;
      lat_timer  <= 8'h00;
      int_line   <= 8'h00;
      rsp_valid  <= 1'b0;
      rsp_data   <= 21'h0;
      pass_valid <= 1'b0;
      pass_data  <= 21'h0;
    end else begin
      sticky <= (sticky & ~ev_clr) | ev_set;
      if (do_wr) begin
        case (addr)
          8'h04:   cmd[7:0]   <= wbyte;
          8'h05:   cmd[9:8]   <= wbyte[1:0];
          8'h0C:   cache_line <= wbyte;
          8'h0D:   lat_timer  <= wbyte;
          8'h3C:   int_line   <= wbyte;
          default: ;
        endcase
      end
      rsp_valid  <= cfg;
      rsp_data   <= cfg ? {req_data[20:16], rd_byte, addr} : rsp_data;
      pass_valid <= req_valid && !wr && !rd;
      pass_data  <= (req_valid && !wr && !rd) ? req_data : pass_data;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |=> rsp_valid);  // R11
  AST_PASS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wr && !rd) |=> (pass_valid && !rsp_valid));  // R13
  AST_CMD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[7:0] == 8'h05) |-> (rsp_data[15:10] == 6'b0));  // R2
  AST_SERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serr |=> sticky[4]);  // R5
  AST_SPECIAL_NO_MA: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_master_abort && ev_special_cycle && !sticky[3]) |=> !sticky[3]);  // R6
  AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky[5]) |-> $past(do_wr && addr == 8'h07 && wbyte[7]));  // R3

endmodule

// File: tb/pci_cfg_space_test.sv
module pci_cfg_space_test;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [20:0] req_data = '0;
  logic ev_parity_err = 0, ev_serr = 0, ev_master_abort = 0, ev_special_cycle = 0;
  logic ev_target_abort_rcvd = 0, ev_target_abort_sig = 0, ev_master_data_perr = 0;
  logic rsp_valid, pass_valid;
  logic [20:0] rsp_data, pass_data;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  pci_cfg_space uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic [2:0] fn, logic [7:0] a, logic [7:0] wd,
                        logic w, logic r, logic [7:0] exp);
    req_valid = 1; req_data = {fn, r, w, wd, a};
    @(negedge clk);
    cmp({tag, " valid"}, 32'(rsp_valid), 32'd1);
    cmp(tag, 32'(rsp_data), 32'({fn, r, w, exp, a}));
    req_valid = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [7:0] exp);
    access(tag, 3'd0, a, 8'h00, 1'b0, 1'b1, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    req_valid = 1; req_data = {3'd0, 1'b0, 1'b1, d, a};
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse(logic [6:0] e);
    {ev_parity_err, ev_serr, ev_master_abort, ev_target_abort_rcvd,
     ev_target_abort_sig, ev_master_data_perr, ev_special_cycle} = e;
    @(negedge clk);
    {ev_parity_err, ev_serr, ev_master_abort, ev_target_abort_rcvd,
     ev_target_abort_sig, ev_master_data_perr, ev_special_cycle} = '0;
  endtask

  task automatic t_reset;
    rd("R1 cmd lo", 8'h04, 8'h80);
    rd("R1 cmd hi", 8'h05, 8'h00);
    rd("R1 sts lo", 8'h06, 8'hA0);
    rd("R1 sts hi", 8'h07, 8'h02);
  endtask

  task automatic t_command;
    wr(8'h04, 8'hFF);
    wr(8'h05, 8'hFF);
    rd("R2 cmd lo", 8'h04, 8'hFF);
    rd("R2 cmd hi", 8'h05, 8'h03);
    wr(8'h05, 8'h00);
    rd("R2 cmd hi cleared", 8'h05, 8'h00);
  endtask

  task automatic t_fixed;
    wr(8'h06, 8'hFF);
    wr(8'h07, 8'h06);
    rd("R4 sts lo", 8'h06, 8'hA0);
    rd("R4 sts hi", 8'h07, 8'h02);
  endtask

  task automatic t_events;
    pulse(7'b1111110);
    rd("R5 all set", 8'h07, 8'hFB);
    wr(8'h07, 8'h00);
    rd("R3 zero keeps", 8'h07, 8'hFB);
    wr(8'h07, 8'h40);
    rd("R3 clear serr", 8'h07, 8'hBB);
    wr(8'h07, 8'hFF);
    rd("R3 clear all", 8'h07, 8'h02);
  endtask

  task automatic t_special;
    pulse(7'b0010001);
    rd("R6 special abort", 8'h07, 8'h02);
    pulse(7'b0010000);
    rd("R5 master abort", 8'h07, 8'h22);
    wr(8'h07, 8'hFF);
  endtask

  task automatic t_collide;
    pulse(7'b1000000);
    rd("R5 parity", 8'h07, 8'h82);
    ev_target_abort_rcvd = 1;
    access("R7 write", 3'd0, 8'h07, 8'h90, 1'b1, 1'b0, 8'h82);
    ev_target_abort_rcvd = 0;
    rd("R7 set wins", 8'h07, 8'h12);
    wr(8'h07, 8'hFF);
    rd("R7 cleared after", 8'h07, 8'h02);
  endtask

  task automatic t_ident;
    rd("R8 vendor lo", 8'h00, 8'h34);
    rd("R8 vendor hi", 8'h01, 8'h12);
    rd("R8 device lo", 8'h02, 8'h3C);
    rd("R8 device hi", 8'h03, 8'h5A);
    rd("R8 revision", 8'h08, 8'h03);
    rd("R8 class 0", 8'h09, 8'h00);
    rd("R8 class 1", 8'h0A, 8'h40);
    rd("R8 class 2", 8'h0B, 8'h0B);
    rd("R8 subven lo", 8'h2C, 8'h34);
    rd("R8 subsys lo", 8'h2E, 8'hC1);
    rd("R8 int pin", 8'h3D, 8'h01);
    rd("R8 min gnt", 8'h3E, 8'h04);
    rd("R8 max lat", 8'h3F, 8'h08);
    wr(8'h00, 8'hFF);
    wr(8'h3D, 8'hFF);
    rd("R8 vendor ro", 8'h00, 8'h34);
    rd("R8 int pin ro", 8'h3D, 8'h01);
  endtask

  task automatic t_rw;
    rd("R9 cache reset", 8'h0C, 8'h00);
    wr(8'h0C, 8'h10);
    wr(8'h0D, 8'h40);
    wr(8'h3C, 8'h0B);
    wr(8'h0E, 8'hFF);
    rd("R9 cache", 8'h0C, 8'h10);
    rd("R9 latency", 8'h0D, 8'h40);
    rd("R9 int line", 8'h3C, 8'h0B);
    rd("R9 header", 8'h0E, 8'h00);
    rd("R9 bist", 8'h0F, 8'h00);
  endtask

  task automatic t_unimpl;
    wr(8'h10, 8'hFF);
    wr(8'h30, 8'hFF);
    wr(8'h34, 8'hFF);
    rd("R10 bar0", 8'h10, 8'h00);
    rd("R10 rom", 8'h30, 8'h00);
    rd("R10 cap ptr", 8'h34, 8'h00);
    rd("R10 bar5", 8'h27, 8'h00);
  endtask

  task automatic t_resp;
    access("R11 rw old byte", 3'd0, 8'h0C, 8'h22, 1'b1, 1'b1, 8'h10);
    rd("R11 new byte", 8'h0C, 8'h22);
    @(negedge clk);
    cmp("R11 idle no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_func;
    access("R12 fn3 read", 3'd3, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00);
    access("R12 fn2 write", 3'd2, 8'h0C, 8'h55, 1'b1, 1'b0, 8'h00);
    rd("R12 fn0 intact", 8'h0C, 8'h22);
  endtask

  task automatic t_pass;
    req_valid = 1; req_data = {3'd5, 2'b00, 8'hC3, 8'h44};
    @(negedge clk);
    req_valid = 0;
    cmp("R13 pass valid", 32'(pass_valid), 32'd1);
    cmp("R13 pass data", 32'(pass_data), 32'({3'd5, 2'b00, 8'hC3, 8'h44}));
    cmp("R13 no rsp", 32'(rsp_valid), 32'd0);
    rd("R13 cfg no pass", 8'h04, 8'hFF);
    cmp("R13 pass idle", 32'(pass_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_command();
    t_fixed();
    t_events();
    t_special();
    t_collide();
    t_ident();
    t_rw();
    t_unimpl();
    t_resp();
    t_func();
    t_pass();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule